// File: doc/BRIEF.md
# Four-Bit Bidirectional Port with Direction Control

This block is a small general-purpose I/O port for a microcontroller peripheral bus. It holds two 4-bit registers: a direction register that makes each pin an output or an input, and an output data register that supplies the value driven on output pins. Both registers sit in an 8-bit register slot. Only the low four bits are implemented. The upper four bits ignore writes and read as zero.

A read of the data slot is assembled bit by bit. A pin set as an output returns its latched output data. A pin set as an input returns its live level, taken after a two-flop synchronizer. Two reset classes behave differently. A power-on reset or a hardware standby request clears both registers at once, which turns every pin into an input. A manual reset or a software standby request keeps both registers and only blocks writes, so the pins hold their state. Pin 3 also serves as an external conversion trigger for an ADC. The trigger path is live only when the ADC's 2-bit trigger-select code is 11 and pin 3 is an input.

Top module: `gpio_dir_port`

## Requirements
- R1: After a power-on reset (`rst_n` low), the direction and output data registers are 0. `pin_oe_o` and `pin_o` read 0, and a data read returns the synchronized pin levels.
- R2: A write with `wr_en_i`=1 and `sel_i`=0 loads `wdata_i[3:0]` into the direction register at the next clock edge. A read with `sel_i`=0 returns it in `rdata_o[3:0]`.
- R3: A write with `wr_en_i`=1 and `sel_i`=1 loads `wdata_i[3:0]` into the output data register at the next clock edge. `pin_o` equals that register, and `pin_oe_o` equals the direction register bit by bit.
- R4: A read with `sel_i`=1 returns, for each bit n, output data bit n when direction bit n is 1, and the synchronized level of `pin_i[n]` when direction bit n is 0.
- R5: A change on `pin_i` reaches the read path and the trigger output after exactly two rising clock edges, not after one.
- R6: Raising `hstby_i` clears both registers without waiting for a clock edge. They stay cleared after `hstby_i` falls until they are written again.
- R7: While `soft_rst_i` is 1, both registers keep their values and writes to either register have no effect.
- R8: While `sw_stby_i` is 1, both registers keep their values and writes to either register have no effect.
- R9: `adc_trig_o` equals the synchronized level of pin 3 when `trg_sel_i` is 2'b11 and direction bit 3 is 0. Otherwise it is 0.
- R10: Bits 7 to 4 of `wdata_i` are ignored, and `rdata_o[7:4]` is always 0 for both register selections.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| hstby_i | input | 1 | Hardware standby request; clears the registers asynchronously |
| soft_rst_i | input | 1 | Manual reset; registers are retained and writes are blocked |
| sw_stby_i | input | 1 | Software standby; registers are retained and writes are blocked |
| sel_i | input | 1 | Register select: 0 = direction, 1 = data |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data; only bits 3:0 are used |
| rdata_o | output | 8 | Read data for the selected register |
| pin_i | input | 4 | Pin levels from the pads |
| pin_o | output | 4 | Output data to the pads |
| pin_oe_o | output | 4 | Per-pin output enable to the pads |
| trg_sel_i | input | 2 | ADC trigger-select code |
| adc_trig_o | output | 1 | External ADC trigger taken from pin 3 |

## Verification
The bench builds the port with its defaults: four pins, an 8-bit register slot, a two-stage synchronizer and the trigger on pin 3. With these values the mixed read in R4 can be checked with inputs and outputs interleaved in one pattern. The exact two-edge latency in R5 can be counted edge by edge. The trigger gate in R9 sits on the same pin whose direction bit the bench toggles. The reserved upper bits in R10 stay real bits of the slot, so a write into them can be seen to have no effect.

// File: rtl/port_pkg.sv
package port_pkg;
  typedef enum logic {
    SEL_DIR  = 1'b0,
    SEL_DATA = 1'b1
  } reg_sel_e;

  localparam logic [1:0] TRIG_EXT_CODE = 2'b11;
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdc_sync_bits.sv
module pdc_sync_bits #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pdc_ctrl_regs.sv
module pdc_ctrl_regs #(
  parameter int W     = 4,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  port_pkg::reg_sel_e sel_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             freeze_i,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     dout_o
);
  import port_pkg::*;

  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] dout_q, dout_d;
  logic         wr_ok;

  always_comb begin
    wr_ok  = wr_en_i && !freeze_i;
    dir_d  = dir_q;
    dout_d = dout_q;
    if (wr_ok && sel_i == SEL_DIR)  dir_d  = wdata_i[W-1:0];
    if (wr_ok && sel_i == SEL_DATA) dout_d = wdata_i[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
    end else begin
      dir_q  <= dir_d;
      dout_q <= dout_d;
    end
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port #(
  parameter int PORT_W      = 4,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TRIG_PIN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hstby_i,
  input  logic              soft_rst_i,
  input  logic              sw_stby_i,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [PORT_W-1:0] pin_i,
  output logic [PORT_W-1:0] pin_o,
  output logic [PORT_W-1:0] pin_oe_o,
  input  logic [1:0]        trg_sel_i,
  output logic              adc_trig_o
);
  import port_pkg::*;

  localparam int PAD_W = REG_W - PORT_W;

  logic              clr_n;
  logic              core_rst_n;
  logic              freeze;
  reg_sel_e          sel;
  logic [PORT_W-1:0] dir;
  logic [PORT_W-1:0] dout;
  logic [PORT_W-1:0] pin_s;
  logic [PORT_W-1:0] rd_bits;

  assign clr_n  = rst_n & ~hstby_i;
  assign freeze = soft_rst_i | sw_stby_i;
  assign sel    = reg_sel_e'(sel_i);

  pdc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk      (clk),
    .arst_n_i (clr_n),
    .rst_n_o  (core_rst_n)
  );

  pdc_sync_bits #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  pdc_ctrl_regs #(.W(PORT_W), .REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en_i  (wr_en_i),
    .sel_i    (sel),
    .wdata_i  (wdata_i),
    .freeze_i (freeze),
    .dir_o    (dir),
    .dout_o   (dout)
  );

  for (genvar b = 0; b < PORT_W; b++) begin : g_rd
    assign rd_bits[b] = dir[b] ? dout[b] : pin_s[b];
  end

  always_comb begin
    if (sel == SEL_DIR) rdata_o = {{PAD_W{1'b0}}, dir};
    else                rdata_o = {{PAD_W{1'b0}}, rd_bits};
  end

  assign pin_o      = dout;
  assign pin_oe_o   = dir;
  assign adc_trig_o = (trg_sel_i == TRIG_EXT_CODE) && !dir[TRIG_PIN] && pin_s[TRIG_PIN];
endmodule

// File: rtl/gpio_dir_port_chk.sv
module gpio_dir_port_chk #(
  parameter int PORT_W = 4,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              soft_rst_i,
  input logic              sw_stby_i,
  input logic              sel_i,
  input logic              wr_en_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [PORT_W-1:0] pin_o,
  input logic [PORT_W-1:0] pin_oe_o,
  input logic [1:0]        trg_sel_i,
  input logic              adc_trig_o
);
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en_i && !sel_i && !soft_rst_i && !sw_stby_i) |=> pin_oe_o == $past(wdata_i[PORT_W-1:0])); // R2

  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en_i && sel_i && !soft_rst_i && !sw_stby_i) |=> pin_o == $past(wdata_i[PORT_W-1:0])); // R3

  AST_OE_READBACK: assert property (@(posedge clk) disable iff (!core_rst_n)
    !sel_i |-> rdata_o[PORT_W-1:0] == pin_oe_o); // R3

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    soft_rst_i |=> $stable(pin_oe_o) && $stable(pin_o)); // R7

  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    sw_stby_i |=> $stable(pin_oe_o) && $stable(pin_o)); // R8

  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!core_rst_n)
    (trg_sel_i != 2'b11 || pin_oe_o[3]) |-> !adc_trig_o); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    rdata_o[REG_W-1:PORT_W] == '0); // R10
endmodule

bind gpio_dir_port gpio_dir_port_chk #(.PORT_W(PORT_W), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .soft_rst_i (soft_rst_i),
  .sw_stby_i  (sw_stby_i),
  .sel_i      (sel_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pin_o      (pin_o),
  .pin_oe_o   (pin_oe_o),
  .trg_sel_i  (trg_sel_i),
  .adc_trig_o (adc_trig_o)
);

// File: tb/test_gpio_dir_port.sv
`timescale 1ns/1ps
module test_gpio_dir_port;
  logic       clk = 1'b0;
  logic       rst_n, hstby_i, soft_rst_i, sw_stby_i, sel_i, wr_en_i;
  logic [7:0] wdata_i, rdata_o;
  logic [3:0] pin_i, pin_o, pin_oe_o;
  logic [1:0] trg_sel_i;
  logic       adc_trig_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_dir_port i_gpio_dir_port (
    .clk(clk), .rst_n(rst_n), .hstby_i(hstby_i), .soft_rst_i(soft_rst_i),
    .sw_stby_i(sw_stby_i), .sel_i(sel_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
    .trg_sel_i(trg_sel_i), .adc_trig_o(adc_trig_o)
  );

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic s, logic [7:0] d);
    sel_i = s; wdata_i = d; wr_en_i = 1'b1;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic s, output logic [7:0] d);
    sel_i = s;
    #0.5;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] r;
    pin_i = 4'hA;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    check("R1 oe", {4'h0, pin_oe_o}, 8'h00);
    check("R1 out", {4'h0, pin_o}, 8'h00);
    rd(1'b1, r);
    check("R1 read pins", r, 8'h0A);
  endtask

  task automatic t_dir_data;
    logic [7:0] r;
    wr(1'b0, 8'hF6);
    rd(1'b0, r);
    check("R2 dir readback", r, 8'h06);
    check("R10 upper ignored", r & 8'hF0, 8'h00);
    wr(1'b1, 8'h5C);
    check("R3 pin_o", {4'h0, pin_o}, 8'h0C);
    check("R3 pin_oe", {4'h0, pin_oe_o}, 8'h06);
  endtask

  task automatic t_mixed_read;
    logic [7:0] r;
    wr(1'b0, 8'h05);
    wr(1'b1, 8'hF3);
    pin_i = 4'b1100;
    tick(2);
    rd(1'b1, r);
    check("R4 mixed read", r, 8'h09);
    check("R10 data upper", r & 8'hF0, 8'h00);
  endtask

  task automatic t_sync;
    logic [7:0] r;
    wr(1'b0, 8'h00);
    pin_i = 4'h0;
    tick(2);
    pin_i = 4'h6;
    tick(1);
    rd(1'b1, r);
    check("R5 one edge", r, 8'h00);
    tick(1);
    rd(1'b1, r);
    check("R5 two edges", r, 8'h06);
  endtask

  task automatic t_hstby;
    wr(1'b0, 8'h0F);
    wr(1'b1, 8'h0F);
    hstby_i = 1'b1;
    #0.5;
    check("R6 async clear oe", {4'h0, pin_oe_o}, 8'h00);
    check("R6 async clear out", {4'h0, pin_o}, 8'h00);
    tick(2);
    hstby_i = 1'b0;
    tick(4);
    check("R6 stays clear", {pin_o, pin_oe_o}, 8'h00);
  endtask

  task automatic t_soft;
    logic [7:0] r;
    wr(1'b0, 8'h03);
    wr(1'b1, 8'h01);
    soft_rst_i = 1'b1;
    wr(1'b0, 8'h0C);
    wr(1'b1, 8'h0E);
    soft_rst_i = 1'b0;
    rd(1'b0, r);
    check("R7 dir held", r, 8'h03);
    check("R7 data held", {4'h0, pin_o}, 8'h01);
    sw_stby_i = 1'b1;
    wr(1'b0, 8'h0F);
    wr(1'b1, 8'h08);
    sw_stby_i = 1'b0;
    rd(1'b0, r);
    check("R8 dir held", r, 8'h03);
    check("R8 data held", {4'h0, pin_o}, 8'h01);
  endtask

  task automatic t_trig;
    wr(1'b0, 8'h00);
    pin_i = 4'h8;
    trg_sel_i = 2'b11;
    tick(2);
    check("R9 trig live", {7'h0, adc_trig_o}, 8'h01);
    trg_sel_i = 2'b10;
    #0.5;
    check("R9 code 10 blocks", {7'h0, adc_trig_o}, 8'h00);
    trg_sel_i = 2'b01;
    #0.5;
    check("R9 code 01 blocks", {7'h0, adc_trig_o}, 8'h00);
    trg_sel_i = 2'b11;
    wr(1'b0, 8'h08);
    check("R9 output pin blocks", {7'h0, adc_trig_o}, 8'h00);
    wr(1'b0, 8'h00);
    pin_i = 4'h0;
    tick(2);
    check("R9 follows pin low", {7'h0, adc_trig_o}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; hstby_i = 1'b0; soft_rst_i = 1'b0; sw_stby_i = 1'b0;
    sel_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0; pin_i = '0; trg_sel_i = 2'b00;
    t_reset();
    t_dir_data();
    t_mixed_read();
    t_sync();
    t_hstby();
    t_soft();
    t_trig();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule